// File: doc/BRIEF.md
# RMII Read-Response Frame Transmitter

This block sends one Ethernet II frame over a two-bit RMII transmit interface each time it is asked to return a read result to the host. It runs on the 50 MHz RMII reference clock, so 100 Mbps is two bits per clock. A single-cycle start pulse carries the echoed 16-bit address and the 16-bit read data. The block then drives the whole frame by itself: the preamble and start delimiter, the host's address, the board's own address, the EtherType, a payload and a CRC-32 check sequence. Only read responses use this path. Write requests never pulse `start`.

Every frame is the same length, 72 bytes or 288 clocks. The five response bytes are always padded with zeros up to the 46-byte minimum payload. Both MAC addresses, the EtherType (0x88B5 by default) and the response opcode are fixed when the block is built. After each frame the line stays idle for the inter-frame gap. A request that arrives while a frame or gap is in progress is kept and sent as soon as the gap ends.

Top module: `rmii_resp_tx`

## Requirements
- R1: While `rst` is high and after it is released, `tx_en` is 0, `txd` is 2'b00 and `busy` is 0. Whenever `tx_en` is 0, `txd` is 2'b00.
- R2: A frame keeps `tx_en` high for exactly 288 consecutive clocks, which is 72 bytes of four dibits each.
- R3: Each byte goes out least significant dibit first, one dibit per clock. Byte 0 sits in `txd` for 1st..4th clock as bits [1:0],[3:2],[5:4],[7:6]. Frame bytes 0..6 are 0x55 and byte 7 is 0xD5.
- R4: Bytes 8..13 are the destination address, most significant byte of the 48-bit parameter first. Bytes 14..19 are the source address in the same order. Bytes 20..21 are the EtherType, high byte first.
- R5: Bytes 22..67 form the 46-byte payload. Byte 22 is the opcode, then address high, address low, data high, data low. Bytes 27..67 are 0x00.
- R6: Bytes 68..71 carry the CRC-32 of bytes 8..67. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and processes each byte's bits LSB first. The result is inverted and sent least significant byte first.
- R7: When the block is idle, `tx_en` rises on the clock edge right after the edge that samples `start` high.
- R8: Between the fall of `tx_en` and its next rise there are at least 48 idle clocks. A request that is waiting starts after exactly 48.
- R9: A `start` during a frame or gap is held pending, one request deep. If several arrive, the address and data of the latest one are sent.
- R10: `busy` is high from the first frame clock until the last gap clock. Without `start` the block stays idle with `tx_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz RMII reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a read response |
| rd_addr | input | 16 | Address echoed in the response, sampled with `start` |
| rd_data | input | 16 | Read data returned, sampled with `start` |
| tx_en | output | 1 | RMII transmit enable |
| txd | output | 2 | RMII transmit dibit |
| busy | output | 1 | Frame or inter-frame gap in progress |

## Verification
From an idle state, a `start` sampled at one edge brings `tx_en` high after the next edge. The bench drives `start` for one falling-edge-to-falling-edge window and expects `tx_en` at the very next falling edge. It then samples one dibit at each falling edge for exactly 288 samples, builds the 72 bytes and compares every field with a frame and CRC it computes itself. The gap is checked by counting low falling-edge samples from the first idle clock: a pending request must show exactly 48 before `tx_en` rises again. `busy` must still be high at the first gap sample and low at the 49th.

// File: rtl/rmii_tx_pkg.sv
`timescale 1ns/1ps
package rmii_tx_pkg;

    // Frame layout, in bytes
    localparam int PRE_BYTES       = 8;
    localparam int MAC_BYTES       = 6;
    localparam int TYPE_BYTES      = 2;
    localparam int PAYLOAD_BYTES   = 46;
    localparam int RESP_BYTES      = 5;
    localparam int FCS_BYTES       = 4;
    localparam int DIBITS_PER_BYTE = 4;

    localparam int DST_POS     = PRE_BYTES;
    localparam int SRC_POS     = DST_POS + MAC_BYTES;
    localparam int TYPE_POS    = SRC_POS + MAC_BYTES;
    localparam int PAY_POS     = TYPE_POS + TYPE_BYTES;
    localparam int FCS_POS     = PAY_POS + PAYLOAD_BYTES;
    localparam int FRAME_BYTES = FCS_POS + FCS_BYTES;
    localparam int FRAME_CLKS  = FRAME_BYTES * DIBITS_PER_BYTE;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    localparam logic [7:0]  PRE_OCTET = 8'h55;
    localparam logic [7:0]  SFD_OCTET = 8'hD5;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
    } resp_word_t;

    // One byte step of the reflected CRC-32
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  octet);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ octet[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    // Byte at a position before the check sequence
    function automatic logic [7:0] frame_byte(input int unsigned pos,
                                              input logic [47:0] dst,
                                              input logic [47:0] src,
                                              input logic [15:0] etype,
                                              input logic [7:0]  opc,
                                              input resp_word_t  w);
        logic [7:0] b;
        b = 8'h00;
        if (pos < PRE_BYTES - 1)
            b = PRE_OCTET;
        else if (pos == PRE_BYTES - 1)
            b = SFD_OCTET;
        else if (pos < SRC_POS)
            b = 8'(dst >> (8 * (SRC_POS - 1 - pos)));
        else if (pos < TYPE_POS)
            b = 8'(src >> (8 * (TYPE_POS - 1 - pos)));
        else if (pos < PAY_POS)
            b = 8'(etype >> (8 * (PAY_POS - 1 - pos)));
        else begin
            case (pos - PAY_POS)
                0:       b = opc;
                1:       b = w.addr[15:8];
                2:       b = w.addr[7:0];
                3:       b = w.data[15:8];
                4:       b = w.data[7:0];
                default: b = 8'h00;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/rmii_tx_hold.sv
`timescale 1ns/1ps
module rmii_tx_hold
    import rmii_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  resp_word_t op_new,
    input  logic       take,
    output logic       req,
    output resp_word_t op_out
);

    logic       pend_q;
    resp_word_t held_q;

    assign req    = start | pend_q;
    assign op_out = start ? op_new : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= '0;
        end else begin
            if (start) held_q <= op_new;
            if (take)
                pend_q <= 1'b0;
            else if (start)
                pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rmii_tx_seq.sv
`timescale 1ns/1ps
module rmii_tx_seq
    import rmii_tx_pkg::*;
#(
    parameter int IFG_CLKS = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  resp_word_t       op_in,
    output logic             take,
    output tx_state_e        state,
    output logic [IDX_W-1:0] byte_idx,
    output logic [1:0]       dibit,
    output logic             byte_last,
    output resp_word_t       frame_op
);

    localparam int GAP_W = $clog2(IFG_CLKS + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic             gap_last;
    logic             frame_last;

    assign byte_last  = (dibit == 2'(DIBITS_PER_BYTE - 1));
    assign frame_last = (byte_idx == IDX_W'(FRAME_BYTES - 1));
    assign gap_last   = (gap_cnt == GAP_W'(IFG_CLKS - 1));
    assign take       = req && ((state == ST_IDLE) ||
                                (state == ST_GAP && gap_last));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            dibit    <= '0;
            gap_cnt  <= '0;
            frame_op <= '0;
        end else if (take) begin
            state    <= ST_SEND;
            byte_idx <= '0;
            dibit    <= '0;
            gap_cnt  <= '0;
            frame_op <= op_in;
        end else begin
            case (state)
                ST_SEND: begin
                    dibit <= dibit + 2'd1;
                    if (byte_last) begin
                        if (frame_last) begin
                            state   <= ST_GAP;
                            gap_cnt <= '0;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_last) state <= ST_IDLE;
                    else          gap_cnt <= gap_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rmii_tx_crc.sv
`timescale 1ns/1ps
module rmii_tx_crc
    import rmii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  octet,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init)
            crc <= CRC_SEED;
        else if (step)
            crc <= crc32_byte(crc, octet);
    end

endmodule

// File: rtl/rmii_tx_bytemux.sv
`timescale 1ns/1ps
module rmii_tx_bytemux
    import rmii_tx_pkg::*;
#(
    parameter logic [47:0] DST_MAC   = 48'h0,
    parameter logic [47:0] SRC_MAC   = 48'h0,
    parameter logic [15:0] ETHERTYPE = 16'h88B5,
    parameter logic [7:0]  RESP_OP   = 8'h01
) (
    input  logic [IDX_W-1:0] byte_idx,
    input  resp_word_t       frame_op,
    input  logic [31:0]      crc,
    output logic [7:0]       octet
);

    logic [7:0]       tbl [FCS_POS];
    logic [IDX_W-1:0] fcs_off;
    logic [31:0]      fcs_val;

    for (genvar g = 0; g < FCS_POS; g++) begin : g_tbl
        assign tbl[g] = frame_byte(g, DST_MAC, SRC_MAC, ETHERTYPE, RESP_OP, frame_op);
    end

    assign fcs_off = byte_idx - IDX_W'(FCS_POS);
    assign fcs_val = ~crc;

    always_comb begin
        if (byte_idx < IDX_W'(FCS_POS))
            octet = tbl[byte_idx];
        else
            octet = 8'(fcs_val >> {fcs_off[1:0], 3'b000});
    end

endmodule

// File: rtl/rmii_resp_tx.sv
`timescale 1ns/1ps
module rmii_resp_tx
    import rmii_tx_pkg::*;
#(
    parameter logic [47:0] DST_MAC   = 48'h02_00_00_00_00_01,
    parameter logic [47:0] SRC_MAC   = 48'h02_00_00_00_00_02,
    parameter logic [15:0] ETHERTYPE = 16'h88B5,
    parameter logic [7:0]  RESP_OP   = 8'h01,
    parameter int          IFG_CLKS  = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] rd_addr,
    input  logic [15:0] rd_data,
    output logic        tx_en,
    output logic [1:0]  txd,
    output logic        busy
);

    resp_word_t       op_new, op_sel, frame_op;
    logic             req, take, byte_last, crc_step;
    tx_state_e        state;
    logic [IDX_W-1:0] byte_idx;
    logic [1:0]       dibit;
    logic [31:0]      crc;
    logic [7:0]       octet;

    assign op_new = '{addr: rd_addr, data: rd_data};

    rmii_tx_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_new (op_new),
        .take   (take),
        .req    (req),
        .op_out (op_sel)
    );

    rmii_tx_seq #(.IFG_CLKS(IFG_CLKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .op_in     (op_sel),
        .take      (take),
        .state     (state),
        .byte_idx  (byte_idx),
        .dibit     (dibit),
        .byte_last (byte_last),
        .frame_op  (frame_op)
    );

    assign crc_step = (state == ST_SEND) && byte_last &&
                      (byte_idx >= IDX_W'(DST_POS)) &&
                      (byte_idx <  IDX_W'(FCS_POS));

    rmii_tx_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (take),
        .step  (crc_step),
        .octet (octet),
        .crc   (crc)
    );

    rmii_tx_bytemux #(
        .DST_MAC   (DST_MAC),
        .SRC_MAC   (SRC_MAC),
        .ETHERTYPE (ETHERTYPE),
        .RESP_OP   (RESP_OP)
    ) u_mux (
        .byte_idx (byte_idx),
        .frame_op (frame_op),
        .crc      (crc),
        .octet    (octet)
    );

    assign tx_en = (state == ST_SEND);
    assign txd   = tx_en ? octet[{dibit, 1'b0} +: 2] : 2'b00;
    assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/rmii_resp_tx_chk.sv
`timescale 1ns/1ps
module rmii_resp_tx_chk #(
    parameter int FRAME_CLKS = 288,
    parameter int IFG_CLKS   = 48
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       tx_en,
    input logic [1:0] txd,
    input logic       busy
);

    logic [9:0] len_cnt;
    logic [7:0] low_cnt;
    logic       seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_cnt    <= '0;
            low_cnt    <= '0;
            seen_frame <= 1'b0;
        end else begin
            len_cnt <= tx_en ? len_cnt + 10'd1 : 10'd0;
            if (tx_en)
                low_cnt <= '0;
            else if (low_cnt != 8'hFF)
                low_cnt <= low_cnt + 8'd1;
            if (!tx_en && len_cnt != 10'd0)
                seen_frame <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> txd == 2'b00);

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> len_cnt == 10'(FRAME_CLKS));

    assert_start_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> tx_en);

    assert_gap_min_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && seen_frame) |-> low_cnt >= 8'(IFG_CLKS));

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> busy);

endmodule

bind rmii_resp_tx rmii_resp_tx_chk #(
    .FRAME_CLKS (rmii_tx_pkg::FRAME_CLKS),
    .IFG_CLKS   (IFG_CLKS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tx_en (tx_en),
    .txd   (txd),
    .busy  (busy)
);

// File: tb/sim_rmii_resp_tx.sv
`timescale 1ns/1ps
module sim_rmii_resp_tx;

    localparam logic [47:0] T_DST  = 48'h3C_97_0E_11_22_33;
    localparam logic [47:0] T_SRC  = 48'h00_0A_35_AB_CD_EF;
    localparam logic [15:0] T_TYPE = 16'h88B5;
    localparam logic [7:0]  T_OP   = 8'h01;
    localparam int          T_IFG  = 48;
    localparam int          NBYTES = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] rd_data = '0;
    logic        tx_en;
    logic [1:0]  txd;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_b [NBYTES];
    logic [7:0] got_b [NBYTES];
    int         got_n;
    int         got_wait;

    int idle_run  = 0;
    int last_idle = 0;
    bit prev_en   = 1'b0;

    always #10 clk = ~clk;

    rmii_resp_tx #(
        .DST_MAC   (T_DST),
        .SRC_MAC   (T_SRC),
        .ETHERTYPE (T_TYPE),
        .RESP_OP   (T_OP),
        .IFG_CLKS  (T_IFG)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tx_en   (tx_en),
        .txd     (txd),
        .busy    (busy)
    );

    // Idle-run monitor at the port
    always @(negedge clk) begin
        if (tx_en) begin
            if (!prev_en) last_idle = idle_run;
            idle_run = 0;
        end else begin
            idle_run = idle_run + 1;
        end
        prev_en = tx_en;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_expected(input logic [15:0] a, input logic [15:0] d);
        logic [31:0] c;
        logic        fb;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        for (int i = 0; i < 6; i++) exp_b[8 + i]  = T_DST[47 - 8*i -: 8];
        for (int i = 0; i < 6; i++) exp_b[14 + i] = T_SRC[47 - 8*i -: 8];
        exp_b[20] = T_TYPE[15:8];
        exp_b[21] = T_TYPE[7:0];
        exp_b[22] = T_OP;
        exp_b[23] = a[15:8];
        exp_b[24] = a[7:0];
        exp_b[25] = d[15:8];
        exp_b[26] = d[7:0];
        for (int i = 27; i < 68; i++) exp_b[i] = 8'h00;
        c = 32'hFFFF_FFFF;
        for (int k = 8; k < 68; k++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ exp_b[k][b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        c = ~c;
        for (int i = 0; i < 4; i++) exp_b[68 + i] = c[8*i +: 8];
    endtask

    // Waits for tx_en, then collects dibits while it stays high
    task automatic recv_frame();
        got_wait = 0;
        got_n    = 0;
        for (int i = 0; i < NBYTES; i++) got_b[i] = 8'h00;
        while (!tx_en && got_wait < 2000) begin
            got_wait++;
            @(negedge clk);
        end
        while (tx_en && got_n < 400) begin
            if (got_n / 4 < NBYTES) got_b[got_n / 4][2*(got_n % 4) +: 2] = txd;
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic compare_range(input int lo, input int hi,
                                 input string req, input string what);
        int bad;
        bad = -1;
        for (int i = lo; i <= hi; i++)
            if (bad < 0 && got_b[i] !== exp_b[i]) bad = i;
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else         check(1'b0, req, $sformatf("%s byte %0d", what, bad),
                           got_b[bad], exp_b[bad]);
    endtask

    task automatic check_frame(input logic [15:0] a, input logic [15:0] d);
        build_expected(a, d);
        check(got_n == 288, "R2", "frame length in clocks", got_n, 288);
        compare_range(0, 7,   "R3", "preamble and delimiter");
        compare_range(8, 21,  "R4", "addresses and ethertype");
        compare_range(22, 67, "R5", "payload");
        compare_range(68, 71, "R6", "check sequence");
    endtask

    // Caller is at a falling edge; returns one falling edge later
    task automatic pulse(input logic [15:0] a, input logic [15:0] d);
        start   = 1'b1;
        rd_addr = a;
        rd_data = d;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // Returns at the first idle sample after the gap
    task automatic finish_gap();
        check(busy == 1'b1, "R10", "busy at first gap clock", busy, 1);
        check(txd == 2'b00, "R1", "txd quiet in gap", txd, 0);
        repeat (T_IFG) @(negedge clk);
        check(busy == 1'b0, "R10", "busy after gap", busy, 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(tx_en == 1'b0 && txd == 2'b00 && busy == 1'b0, "R1",
              "outputs in reset", {tx_en, txd, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0 && txd == 2'b00 && busy == 1'b0, "R1",
              "outputs after reset", {tx_en, txd, busy}, 0);
    endtask

    task automatic test_single(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        pulse(a, d);
        recv_frame();
        check(got_wait == 0, "R7", "start to tx_en latency", got_wait, 0);
        check_frame(a, d);
        finish_gap();
    endtask

    task automatic test_idle();
        bit seen;
        seen = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (tx_en || busy) seen = 1'b1;
        end
        check(!seen, "R10", "no activity without start", seen, 0);
    endtask

    task automatic test_pending_frame();
        @(negedge clk);
        pulse(16'h0102, 16'h0304);
        fork
            recv_frame();
            begin
                repeat (40) @(negedge clk);
                pulse(16'hBEEF, 16'h5A5A);
            end
        join
        check_frame(16'h0102, 16'h0304);
        recv_frame();
        check(last_idle == T_IFG, "R8", "gap before pending frame", last_idle, T_IFG);
        check_frame(16'hBEEF, 16'h5A5A);
        check(got_b[23] == 8'hBE && got_b[26] == 8'h5A, "R9",
              "pending operands sent", {got_b[23], got_b[26]}, 16'hBE5A);
        finish_gap();
    endtask

    task automatic test_pending_gap();
        @(negedge clk);
        pulse(16'h7777, 16'h8888);
        recv_frame();
        check_frame(16'h7777, 16'h8888);
        repeat (10) @(negedge clk);
        pulse(16'hC001, 16'hD00D);
        recv_frame();
        check(last_idle == T_IFG, "R8", "gap with request inside gap", last_idle, T_IFG);
        check_frame(16'hC001, 16'hD00D);
        finish_gap();
    endtask

    task automatic test_overwrite();
        @(negedge clk);
        pulse(16'h1111, 16'h2222);
        fork
            recv_frame();
            begin
                repeat (30) @(negedge clk);
                pulse(16'h3333, 16'h4444);
                repeat (20) @(negedge clk);
                pulse(16'h5555, 16'h6666);
            end
        join
        check_frame(16'h1111, 16'h2222);
        recv_frame();
        check(got_b[23] == 8'h55 && got_b[25] == 8'h66, "R9",
              "latest pending request wins", {got_b[23], got_b[25]}, 16'h5566);
        check_frame(16'h5555, 16'h6666);
        finish_gap();
        test_idle();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        test_reset();
        test_idle();
        test_single(16'h1234, 16'hABCD);
        test_single(16'hFFFF, 16'h0000);
        test_single(16'h0000, 16'hFFFF);
        test_pending_frame();
        test_pending_gap();
        test_overwrite();
        done = 1'b1;
        report();
    end

endmodule